// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command nodes kept in system memory and hands the payload of every node, word by word, to a downstream command consumer. Every node opens with a 32-bit header word. The upper byte of the header gives how many payload words follow it, and the lower 24 bits give the byte address of the next node. The walk is started with a pulse and a 24-bit start pointer. It ends at the first pointer whose bit 23 is set.

Memory is reached through a single-outstanding read port. The block raises a request with a word address and holds it until one valid data beat returns. Payload words leave on a valid/ready stream. The walker waits as long as the consumer is not ready and loses no word. Alongside the walk, the block adds up a bus cost figure for the chain. A node limit protects against lists that loop back on themselves: when it is reached, the walk is aborted and an error flag is raised.

The control is a single state machine with seven states:
- ST_IDLE leaves for ST_CHECK on start.
- ST_CHECK goes to ST_END on a terminator pointer, to ST_ABORT at the node limit, and to ST_HDR otherwise.
- ST_HDR goes to ST_CHECK on an empty node and to ST_FETCH otherwise, in both cases when the header beat returns.
- ST_FETCH goes to ST_EMIT when the data beat returns.
- ST_EMIT, on the ready handshake, goes back to ST_FETCH, or to ST_CHECK after the last word of the node.
- ST_END and ST_ABORT both go back to ST_IDLE after one cycle.

Top module: `chain_dma_walker`

## Requirements
- R1: After reset, busy, done, err, mem_req and out_valid are 0 and cost is 0.
- R2: A header word is decoded as payload length = bits 31:24 (0 to 255) and next node byte pointer = bits 23:0.
- R3: A pointer with bit 23 set ends the walk before any memory request for it. Bits 31:24 of start_addr are ignored. A start pointer with bit 23 set gives done with no memory request and cost 0.
- R4: A pointer is fetched at word address = pointer bits 20:2. Pointer bits 22:21 and 1:0 have no effect on which word is read.
- R5: The payload words are read from the word addresses that follow the header word in turn, and are forwarded in that order.
- R6: A node whose length is 0 forwards no word, and the walk continues at its next pointer.
- R7: cost is cleared on start and rises, for every header read, by 10 plus (5 + length) when the length is nonzero. At done it holds the total for the chain.
- R8: If MAX_NODES headers have been read and the pointer that follows is not a terminator, the walk aborts with err = 1 at done. A chain of exactly MAX_NODES nodes ends with err = 0. err is cleared by the next start.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R10: busy is high from the cycle after an accepted start until the cycle after done. done is a single-cycle pulse. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| start_addr | input | 32 | Byte pointer of the first node (bits 23:0 used) |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | MEM_BYTE_W-2 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid, one beat per request |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Payload word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Walk aborted at the node limit |
| cost | output | COST_W | Accumulated bus cost of the chain |

## Verification
The bench builds the block with MAX_NODES = 12. This lets a self-referencing node reach the abort within a few hundred cycles, and a twelve-node chain sits exactly on the limit. MEM_BYTE_W and COST_W keep their defaults of 21 and 32. The full 19-bit word space is therefore addressed, which lets the next pointers carry stray bits 22:21 that must be ignored. Random memory latency and a randomly withheld ready exercise every wait state of the machine.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;

    localparam int WORD_W     = 32;
    localparam int LEN_W      = 8;
    localparam int PTR_W      = 24;
    localparam int TERM_BIT   = 23;
    localparam int NODE_COST  = 10;
    localparam int BURST_COST = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR,
        ST_FETCH,
        ST_EMIT,
        ST_END,
        ST_ABORT
    } walk_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] next;
    } node_hdr_t;

endpackage

// File: rtl/chain_hdr_decode.sv
module chain_hdr_decode
    import chain_walk_pkg::*;
#(
    parameter int MEM_BYTE_W = 21,
    parameter int COST_W     = 32,
    localparam int WADDR_W   = MEM_BYTE_W - 2
) (
    input  logic [WORD_W-1:0]  word,
    output logic [LEN_W-1:0]   len,
    output logic               empty,
    output logic               nxt_term,
    output logic [WADDR_W-1:0] nxt_word,
    output logic [COST_W-1:0]  node_cost
);
    node_hdr_t hdr;
    logic      unused_hdr_bits;

    always_comb begin
        hdr      = node_hdr_t'(word);
        len      = hdr.len;
        empty    = (hdr.len == '0);
        nxt_term = hdr.next[TERM_BIT];
        nxt_word = hdr.next[MEM_BYTE_W-1:2];
        if (empty) begin
            node_cost = COST_W'(NODE_COST);
        end else begin
            node_cost = COST_W'(NODE_COST) + COST_W'(BURST_COST) + COST_W'(hdr.len);
        end
    end

    // pointer bits outside the memory window carry no meaning
    assign unused_hdr_bits = ^word;

endmodule

// File: rtl/chain_cost_acc.sv
module chain_cost_acc #(
    parameter int COST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [COST_W-1:0] add_val,
    output logic [COST_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clr) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + add_val;
        end
    end
endmodule

// File: rtl/chain_walk_fsm.sv
module chain_walk_fsm
    import chain_walk_pkg::*;
#(
    parameter int MEM_BYTE_W = 21,
    parameter int MAX_NODES  = 8192,
    localparam int WADDR_W   = MEM_BYTE_W - 2,
    localparam int NCNT_W    = $clog2(MAX_NODES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_term,
    input  logic [WADDR_W-1:0] start_word,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic [LEN_W-1:0]   hdr_len,
    input  logic               hdr_empty,
    input  logic               hdr_term,
    input  logic [WADDR_W-1:0] hdr_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               cost_clr,
    output logic               cost_add
);
    walk_state_e state, state_nx;

    logic               cur_term;
    logic [WADDR_W-1:0] cur_word;
    logic               nxt_term_q;
    logic [WADDR_W-1:0] nxt_word_q;
    logic [WADDR_W-1:0] ptr;
    logic [LEN_W-1:0]   remain;
    logic [NCNT_W-1:0]  node_cnt;
    logic               at_limit;
    logic               last_word;

    assign at_limit  = (node_cnt == NCNT_W'(MAX_NODES));
    assign last_word = (remain == LEN_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (cur_term)      state_nx = ST_END;
                else if (at_limit) state_nx = ST_ABORT;
                else               state_nx = ST_HDR;
            end
            ST_HDR:   if (mem_rvalid) state_nx = hdr_empty ? ST_CHECK : ST_FETCH;
            ST_FETCH: if (mem_rvalid) state_nx = ST_EMIT;
            ST_EMIT:  if (out_ready)  state_nx = last_word ? ST_CHECK : ST_FETCH;
            ST_END:   state_nx = ST_IDLE;
            ST_ABORT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_term   <= 1'b0;
            cur_word   <= '0;
            nxt_term_q <= 1'b0;
            nxt_word_q <= '0;
            ptr        <= '0;
            remain     <= '0;
            node_cnt   <= '0;
            out_data   <= '0;
            err        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_term <= start_term;
                        cur_word <= start_word;
                        node_cnt <= '0;
                        err      <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    if (!cur_term && at_limit) err <= 1'b1;
                end
                ST_HDR: begin
                    if (mem_rvalid) begin
                        remain     <= hdr_len;
                        nxt_term_q <= hdr_term;
                        nxt_word_q <= hdr_word;
                        ptr        <= cur_word + WADDR_W'(1);
                        node_cnt   <= node_cnt + NCNT_W'(1);
                        if (hdr_empty) begin
                            cur_term <= hdr_term;
                            cur_word <= hdr_word;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid) out_data <= mem_rdata;
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        remain <= remain - LEN_W'(1);
                        ptr    <= ptr + WADDR_W'(1);
                        if (last_word) begin
                            cur_term <= nxt_term_q;
                            cur_word <= nxt_word_q;
                        end
                    end
                end
                ST_END, ST_ABORT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = '0;
        out_valid = 1'b0;
        done      = 1'b0;
        busy      = (state != ST_IDLE);
        cost_clr  = 1'b0;
        cost_add  = 1'b0;
        unique case (state)
            ST_IDLE:  cost_clr = start;
            ST_CHECK: begin
            end
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_word;
                cost_add = mem_rvalid;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
            end
            ST_EMIT:  out_valid = 1'b1;
            ST_END:   done = 1'b1;
            ST_ABORT: done = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
    import chain_walk_pkg::*;
#(
    parameter int MEM_BYTE_W = 21,
    parameter int COST_W     = 32,
    parameter int MAX_NODES  = 8192,
    localparam int WADDR_W   = MEM_BYTE_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        start_addr,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [31:0]        out_data,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [COST_W-1:0]  cost
);
    logic [LEN_W-1:0]   hdr_len;
    logic               hdr_empty;
    logic               hdr_term;
    logic [WADDR_W-1:0] hdr_word;
    logic [COST_W-1:0]  hdr_cost;
    logic               cost_clr;
    logic               cost_add;
    logic               unused_start_bits;

    // only the 24-bit pointer field of the start address is meaningful
    assign unused_start_bits = ^start_addr;

    chain_hdr_decode #(
        .MEM_BYTE_W (MEM_BYTE_W),
        .COST_W     (COST_W)
    ) hdr_dec_i (
        .word      (mem_rdata),
        .len       (hdr_len),
        .empty     (hdr_empty),
        .nxt_term  (hdr_term),
        .nxt_word  (hdr_word),
        .node_cost (hdr_cost)
    );

    chain_walk_fsm #(
        .MEM_BYTE_W (MEM_BYTE_W),
        .MAX_NODES  (MAX_NODES)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_term (start_addr[TERM_BIT]),
        .start_word (start_addr[MEM_BYTE_W-1:2]),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .hdr_len    (hdr_len),
        .hdr_empty  (hdr_empty),
        .hdr_term   (hdr_term),
        .hdr_word   (hdr_word),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .cost_clr   (cost_clr),
        .cost_add   (cost_add)
    );

    chain_cost_acc #(
        .COST_W (COST_W)
    ) cost_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cost_clr),
        .add_en  (cost_add),
        .add_val (hdr_cost),
        .total   (cost)
    );

endmodule

// File: rtl/chain_dma_walker_chk.sv
module chain_dma_walker_chk #(
    parameter int MEM_BYTE_W = 21,
    parameter int COST_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mem_req,
    input logic [MEM_BYTE_W-3:0] mem_addr,
    input logic                  mem_rvalid,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [31:0]           out_data,
    input logic                  busy,
    input logic                  done,
    input logic                  err,
    input logic [COST_W-1:0]     cost
);
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_req_xor_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && out_valid));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !out_valid && !done));

    p_err_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    p_cost_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cost >= $past(cost)));
endmodule

bind chain_dma_walker chain_dma_walker_chk #(
    .MEM_BYTE_W (MEM_BYTE_W),
    .COST_W     (COST_W)
) chk_i (.*);

// File: tb/chain_dma_walker_tb_top.sv
module chain_dma_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_N      = 12;
    localparam int WA_W       = 19;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     start_addr = '0;
    logic            mem_req;
    logic [WA_W-1:0] mem_addr;
    logic            mem_rvalid;
    logic [31:0]     mem_rdata;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [31:0]     out_data;
    logic            busy, done, err;
    logic [31:0]     cost;

    int n_chk  = 0;
    int n_fail = 0;
    int req_cnt;
    int lat;

    logic [31:0] mem [logic [WA_W-1:0]];
    logic [31:0] exp_q[$];
    logic [31:0] exp_cost;
    bit          exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_dma_walker #(.MAX_NODES(MAX_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .busy(busy), .done(done), .err(err), .cost(cost)
    );

    function automatic logic [31:0] rd(input logic [WA_W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // memory model: one beat per request after a random wait
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            lat        <= 0;
            req_cnt    <= 0;
        end else begin
            if (mem_req) req_cnt <= req_cnt + 1;
            if (mem_rvalid) begin
                mem_rvalid <= 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= rd(mem_addr);
                    lat        <= int'($urandom % 3);
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // reference walk computed from the requirements
    task automatic model_walk(input logic [31:0] sa);
        logic [23:0]     p;
        logic [31:0]     h;
        logic [7:0]      ln;
        logic [WA_W-1:0] w;
        int              nodes;
        p = sa[23:0];
        nodes = 0;
        exp_q.delete();
        exp_cost = 0;
        exp_err = 0;
        while (!p[23]) begin
            if (nodes == MAX_N) begin
                exp_err = 1;
                break;
            end
            w = p[20:2];
            h = rd(w);
            ln = h[31:24];
            nodes++;
            exp_cost += 10 + ((ln != 0) ? (5 + ln) : 0);
            for (int k = 0; k < ln; k++) exp_q.push_back(rd(w + WA_W'(1 + k)));
            p = h[23:0];
        end
    endtask

    function automatic logic [23:0] mkptr(input logic [WA_W-1:0] w, input bit junk);
        logic [1:0] hi;
        hi = junk ? 2'($urandom) : 2'b00;
        return {1'b0, hi, w, 2'($urandom)};
    endfunction

    // random chain of n nodes; returns the start address
    task automatic build_chain(input int n, input int max_len, input bit junk,
                               output logic [31:0] sa);
        logic [WA_W-1:0] base [16];
        logic [7:0]      ln;
        logic [23:0]     nx;
        mem.delete();
        for (int i = 0; i < n; i++) base[i] = WA_W'(i * 512 + int'($urandom % 64));
        for (int i = 0; i < n; i++) begin
            ln = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom % (max_len + 1));
            nx = (i == n - 1) ? {1'b1, 23'($urandom)} : mkptr(base[i+1], junk);
            mem[base[i]] = {ln, nx};
            for (int k = 0; k < ln; k++) mem[base[i] + WA_W'(1 + k)] = $urandom;
        end
        sa = {8'($urandom), mkptr(base[0], junk)};
    endtask

    task automatic run_chain(input logic [31:0] sa, input string tag, input bit inject);
        logic [31:0] got[$];
        logic [31:0] prev_data;
        bit          prev_stall;
        bit          fin;
        int          stall_bad;
        int          cyc;
        int          bad;
        model_walk(sa);
        @(negedge clk);
        start_addr = sa;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10", "busy after start", busy, 1);
        prev_stall = 0; prev_data = '0; fin = 0; stall_bad = 0; cyc = 0;
        while (!fin) begin
            if (inject && cyc == 6) begin
                start = 1'b1;
                start_addr = 32'h0000_0100;
            end else begin
                start = 1'b0;
            end
            out_ready = ($urandom % 4) != 0;
            if (prev_stall && (!out_valid || out_data !== prev_data)) stall_bad++;
            if (out_valid && out_ready) got.push_back(out_data);
            prev_stall = out_valid && !out_ready;
            prev_data = out_data;
            if (done) begin
                fin = 1;
                chk(cost == exp_cost, "R7", "chain cost", cost, exp_cost);
                chk(err == exp_err, "R8", "error flag at done", err, exp_err);
            end
            cyc++;
            if (cyc > 20000) begin
                chk(0, tag, "walk did not finish", cyc, 0);
                break;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        start = 1'b0;
        chk(stall_bad == 0, "R9", "held word under back-pressure", stall_bad, 0);
        chk(got.size() == exp_q.size(), tag, "forwarded word count", got.size(), exp_q.size());
        bad = 0;
        for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
            if (got[i] !== exp_q[i]) begin
                if (bad == 0) chk(0, tag, "payload word", got[i], exp_q[i]);
                bad++;
            end
        end
        if (bad == 0) chk(1, tag, "payload order", 0, 0);
        chk(!done && !busy, "R10", "idle after single done pulse", {done, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] sa;
        int          r0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && !mem_req && !out_valid, "R1", "outputs after reset",
            {busy, done, err, mem_req, out_valid}, 0);
        chk(cost == 0, "R1", "cost after reset", cost, 0);

        // R3 terminator at start, with upper byte set
        mem.delete();
        r0 = req_cnt;
        run_chain(32'hA5_80_0040, "R3", 0);
        chk(req_cnt == r0, "R3", "no memory request for terminator", req_cnt - r0, 0);

        // R6 single empty node: cost 10, nothing forwarded
        mem.delete();
        mem[19'h40] = {8'd0, 24'h80_0000};
        run_chain(32'hFF_00_0100, "R6", 0);
        chk(cost == 10, "R6", "empty node cost", cost, 10);

        // R2 maximum length node then length-1 node
        mem.delete();
        mem[19'h10] = {8'd255, 24'h00_4000};
        for (int k = 0; k < 255; k++) mem[19'h11 + 19'(k)] = 32'hC000_0000 + 32'(k);
        mem[19'h1000] = {8'd1, 24'h80_0000};
        mem[19'h1001] = 32'hDEAD_BEEF;
        run_chain(32'h0000_0040, "R2", 0);
        chk(cost == 286, "R2", "length 255 plus length 1 cost", cost, 286);

        // R4 pointers with stray bits 22:21 and 1:0
        for (int t = 0; t < 4; t++) begin
            build_chain(5, 10, 1, sa);
            run_chain(sa, "R4", 0);
        end

        // R5 random chains, start pulse while busy ignored (R10)
        for (int t = 0; t < 16; t++) begin
            build_chain(1 + int'($urandom % 6), 12, 0, sa);
            run_chain(sa, "R5", (t % 4) == 1);
        end

        // R8 boundary: exactly MAX_N nodes, then a self-loop
        build_chain(MAX_N, 4, 0, sa);
        run_chain(sa, "R8", 0);
        chk(err == 0, "R8", "limit-length chain not aborted", err, 0);
        mem.delete();
        mem[19'h200] = {8'd2, 24'h00_0800};
        mem[19'h201] = 32'h1111_2222;
        mem[19'h202] = 32'h3333_4444;
        run_chain(32'h0000_0800, "R8", 0);
        chk(cost == MAX_N * 17, "R8", "cost at abort", cost, MAX_N * 17);
        // err cleared by a new start
        mem.delete();
        run_chain(32'h0080_0000, "R8", 0);
        chk(err == 0, "R8", "error cleared by next start", err, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule